// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits on the path from a bus master to byte-addressable memory. Two large alias windows map one 32-bit alias word to one bit in a matching small bit-band window. A data read from an alias word comes back as a single isolated bit. A data write to an alias word sets or clears that one bit, and no other bit changes. The bridge does this as a read-modify-write of the containing location. All other traffic reaches memory unchanged. This includes instruction fetches that land in an alias window, and direct accesses to the bit-band windows themselves.

Both ports use the same simple handshake. A request is held with its fields stable until the cycle in which ready is high, and the transfer completes at that clock edge. Read data lanes are little-endian: the byte at address A sits on bits 8*A[1:0]+7 down to 8*A[1:0]. The two phases of an alias write run back to back. The master sees ready only when the write phase completes, so nothing else can reach memory between the read and the write.

Top module: `bb_alias_bridge`

## Requirements
- R1: A request outside both alias windows, or any request with `m_fetch` high, is forwarded with address, write flag, size and write data unchanged. The returned read data is passed back unchanged.
- R2: A data access to alias address 0x22000000 + k targets byte 0x20000000 + (k / 32), bit (k mod 32) / 4, for k below 0x2000000.
- R3: A data access to alias address 0x42000000 + k targets byte 0x40000000 + (k / 32), bit (k mod 32) / 4, with the same limits.
- R4: An alias write drives the target bit to bit 0 of the write data, and write data bits 31:1 have no effect. For example, 0x01 and 0xFF set the bit, while 0x00 and 0x0E clear it.
- R5: An alias read returns 0x00000001 when the target bit is 1 and 0x00000000 when it is 0.
- R6: An alias write issues exactly one memory read and then one memory write to the same address. The master's ready stays low until that write is accepted, so with w wait states per memory access the master waits 2w+1 cycles.
- R7: In an alias write, every bit of the sized location other than the target bit is written back with the value just read.
- R8: An instruction fetch (`m_fetch` = 1) that hits an alias window goes to memory at its own address with no translation.
- R9: Alias memory accesses carry the size of the originating request (0 = byte, 1 = halfword, 2 = word). The memory address is the target byte address aligned down to that size.
- R10: Direct accesses to 0x20000000–0x200FFFFF and 0x40000000–0x400FFFFF behave as ordinary memory reads and writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 1 | Master request valid |
| m_write | input | 1 | Master write (1) or read (0) |
| m_fetch | input | 1 | Request is an instruction fetch |
| m_size | input | 2 | 0 byte, 1 halfword, 2 word |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data, lane-placed |
| m_rdata | output | 32 | Read data to master |
| m_ready | output | 1 | Master transfer completes this cycle |
| s_req | output | 1 | Memory request valid |
| s_write | output | 1 | Memory write (1) or read (0) |
| s_size | output | 2 | Memory access size |
| s_addr | output | 32 | Memory byte address |
| s_wdata | output | 32 | Memory write data, lane-placed |
| s_rdata | input | 32 | Memory read data, lane-placed |
| s_ready | input | 1 | Memory transfer completes this cycle |

## Verification
The assertions assume that the master holds its request and all of its fields steady from the first cycle until ready. They also assume that memory returns stable read data while it holds ready low. The bench drives each request at a falling edge and keeps it unchanged until it sees ready. Its memory model asserts ready only after a fixed wait count for the current request. The bench alternates zero and one wait states, so both the back-to-back and the stretched read-modify-write timing are exercised.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANE_W = $clog2(DATA_W);
  localparam int BITSEL_W = 3;
  localparam int SIZE_W = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [SIZE_W-1:0] size_t;

  typedef enum logic [0:0] {PH_FETCH = 1'b0, PH_STORE = 1'b1} rmw_phase_e;

  // alias word index -> byte offset within the bit-band window
  function automatic addr_t f_byte_offset(addr_t alias_off);
    return alias_off >> (LANE_W);
  endfunction

  // alias word index -> bit number inside the byte
  function automatic logic [BITSEL_W-1:0] f_bit_num(addr_t alias_off);
    return alias_off[BITSEL_W+1:2];
  endfunction

  // align a byte address down to the access size
  function automatic addr_t f_align(addr_t a, size_t sz);
    case (sz)
      2'd0:    return a;
      2'd1:    return {a[ADDR_W-1:1], 1'b0};
      default: return {a[ADDR_W-1:2], 2'b00};
    endcase
  endfunction

  // bit position of a byte-relative bit on the lane-placed data bus
  function automatic lane_t f_lane(logic [1:0] byte_lo, logic [BITSEL_W-1:0] bitn);
    return {byte_lo, bitn};
  endfunction
endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bb_pkg::*;
#(
  parameter int NWIN = 2,
  parameter int WIN_BYTES = 32'h0010_0000,
  parameter logic [NWIN-1:0][ADDR_W-1:0] WIN_BASE   = {32'h4000_0000, 32'h2000_0000},
  parameter logic [NWIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000}
) (
  input  addr_t                 addr,
  output logic                  hit,
  output addr_t                 tgt_byte,
  output logic [BITSEL_W-1:0]   bit_num
);
  localparam addr_t ALIAS_BYTES = addr_t'(WIN_BYTES) * addr_t'(DATA_W);

  logic [NWIN-1:0] hit_w;
  addr_t           off_w [NWIN];
  addr_t           tgt_w [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign off_w[w] = addr - ALIAS_BASE[w];
    assign hit_w[w] = (addr >= ALIAS_BASE[w]) && (off_w[w] < ALIAS_BYTES);
    assign tgt_w[w] = WIN_BASE[w] + f_byte_offset(off_w[w]);
  end

  always_comb begin
    tgt_byte = '0;
    for (int w = 0; w < NWIN; w++)
      if (hit_w[w]) tgt_byte = tgt_byte | tgt_w[w];
  end

  assign hit     = |hit_w;
  assign bit_num = f_bit_num(addr);
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  word_t base,
  input  lane_t lane,
  input  logic  val,
  output word_t merged,
  output logic  picked
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = (lane == lane_t'(i)) ? val : base[i];
  end
  assign picked = base[lane];
endmodule

// File: rtl/bb_rmw_ctrl.sv
module bb_rmw_ctrl
  import bb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  s_ready,
  input  word_t s_rdata,
  output logic  store_phase,
  output word_t snap,
  output logic  fetch_done,
  output logic  store_done
);
  rmw_phase_e ph;

  assign store_phase = (ph == PH_STORE);
  assign fetch_done  = start && !store_phase && s_ready;
  assign store_done  = start && store_phase && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_FETCH;
      snap <= '0;
    end else if (fetch_done) begin
      ph   <= PH_STORE;
      snap <= s_rdata;
    end else if (store_done) begin
      ph   <= PH_FETCH;
    end
  end

  // R6: the write phase follows the read phase directly
  a_r6_store_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> store_phase);
  // R6: the sequence returns to its read phase after the write is taken
  a_r6_back_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> !store_phase);
endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge
  import bb_pkg::*;
#(
  parameter int NWIN = 2,
  parameter int WIN_BYTES = 32'h0010_0000,
  parameter logic [NWIN-1:0][ADDR_W-1:0] WIN_BASE   = {32'h4000_0000, 32'h2000_0000},
  parameter logic [NWIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                m_req,
  input  logic                m_write,
  input  logic                m_fetch,
  input  logic [SIZE_W-1:0]   m_size,
  input  logic [ADDR_W-1:0]   m_addr,
  input  logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W-1:0]   m_rdata,
  output logic                m_ready,
  output logic                s_req,
  output logic                s_write,
  output logic [SIZE_W-1:0]   s_size,
  output logic [ADDR_W-1:0]   s_addr,
  output logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W-1:0]   s_rdata,
  input  logic                s_ready
);
  logic                win_hit;
  addr_t               tgt_byte;
  logic [BITSEL_W-1:0] bit_num;
  lane_t               lane;
  logic                alias_acc;
  logic                alias_rd;
  logic                alias_wr;
  logic                store_phase;
  logic                fetch_done;
  logic                store_done;
  word_t               snap;
  word_t               merged;
  logic                picked_unused;
  logic                rd_bit;
  word_t               merged_rd_unused;

  bb_window_decode #(
    .NWIN(NWIN), .WIN_BYTES(WIN_BYTES), .WIN_BASE(WIN_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) u_dec (
    .addr(m_addr), .hit(win_hit), .tgt_byte(tgt_byte), .bit_num(bit_num)
  );

  assign lane      = f_lane(tgt_byte[1:0], bit_num);
  assign alias_acc = m_req && !m_fetch && win_hit;
  assign alias_rd  = alias_acc && !m_write;
  assign alias_wr  = alias_acc && m_write;

  bb_rmw_ctrl u_rmw (
    .clk(clk), .rst_n(rst_n), .start(alias_wr), .s_ready(s_ready), .s_rdata(s_rdata),
    .store_phase(store_phase), .snap(snap), .fetch_done(fetch_done), .store_done(store_done)
  );

  // write phase: insert the new bit into the captured location
  bb_bit_merge u_wmerge (
    .base(snap), .lane(lane), .val(m_wdata[0]), .merged(merged), .picked(picked_unused)
  );

  // read path: pick the target bit from live memory data
  bb_bit_merge u_rpick (
    .base(s_rdata), .lane(lane), .val(1'b0), .merged(merged_rd_unused), .picked(rd_bit)
  );

  assign s_req   = m_req;
  assign s_size  = m_size;
  assign s_addr  = alias_acc ? f_align(tgt_byte, m_size) : m_addr;
  assign s_write = alias_wr ? store_phase : m_write;
  assign s_wdata = alias_wr ? merged : m_wdata;
  assign m_ready = alias_wr ? store_done : s_ready;
  assign m_rdata = alias_rd ? {{(DATA_W-1){1'b0}}, rd_bit} : s_rdata;

  // R5: an alias read completes with only bit 0 possibly set
  a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_rd && m_ready) |-> (m_rdata[DATA_W-1:1] == '0));
  // R6: the master never completes an alias write on a memory read
  a_r6_ready_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_wr && m_ready) |-> (s_req && s_write));
  // R6: the write phase reuses the address of the read phase
  a_r6_same_location: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> (s_write && s_addr == $past(s_addr)));
  // R7: at most the target bit differs between captured and written data
  a_r7_one_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_wr && store_phase) |-> ($countones(s_wdata ^ snap) <= 1));
  // R9: memory access size follows the master
  a_r9_size_kept: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |-> (s_size == m_size));
  // R8: fetches are never remapped
  a_r8_fetch_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_fetch) |-> (s_addr == m_addr && s_write == m_write));
  // R1: outside the alias windows the request is forwarded unchanged
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !alias_acc) |-> (s_addr == m_addr && s_wdata == m_wdata && m_rdata == s_rdata));
endmodule

// File: tb/bb_alias_bridge_test.sv
module bb_alias_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_req = 1'b0, m_write = 1'b0, m_fetch = 1'b0;
  logic [1:0]  m_size = 2'd2;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic [31:0] m_rdata;
  logic        m_ready;
  logic        s_req, s_write;
  logic [1:0]  s_size;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic        s_ready;

  int vecs = 0;
  int bad  = 0;
  int ws   = 0;
  int wcnt = 0;
  int mem_wr_cnt = 0;
  logic [7:0] mem [0:511];
  logic [7:0] sh  [0:511];

  always #5 clk = ~clk;

  bb_alias_bridge uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_write(m_write), .m_fetch(m_fetch),
    .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
    .s_req(s_req), .s_write(s_write), .s_size(s_size), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata), .s_ready(s_ready)
  );

  function automatic int ix(logic [31:0] a);
    return int'({a[30], a[7:0]});
  endfunction

  // memory model: lane-placed little-endian, fixed wait count per request
  assign s_ready = s_req && (wcnt >= ws);
  assign s_rdata = {mem[ix({s_addr[31:2], 2'd3})], mem[ix({s_addr[31:2], 2'd2})],
                    mem[ix({s_addr[31:2], 2'd1})], mem[ix({s_addr[31:2], 2'd0})]};

  always_ff @(posedge clk) begin
    if (s_req && !s_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (s_req && s_write && s_ready) begin
      mem_wr_cnt <= mem_wr_cnt + 1;
      for (int b = 0; b < 4; b++) begin
        if (s_size >= 2'd2 || (s_size == 2'd1 && (b / 2) == int'(s_addr[1])) ||
            (s_size == 2'd0 && b == int'(s_addr[1:0])))
          mem[ix({s_addr[31:2], 2'(b)})] <= s_wdata[8*b +: 8];
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic w, input logic [1:0] sz,
                      input logic [31:0] wd, input logic f,
                      output logic [31:0] rd, output int waits,
                      output logic [31:0] sa, output logic [1:0] ssz);
    @(negedge clk);
    m_req = 1'b1; m_addr = a; m_write = w; m_size = sz; m_wdata = wd; m_fetch = f;
    #1;
    sa = s_addr; ssz = s_size; waits = 0;
    while (!m_ready) begin
      @(negedge clk); #1; waits++;
    end
    rd = m_rdata;
    @(posedge clk); #1;
    m_req = 1'b0; m_write = 1'b0; m_fetch = 1'b0;
  endtask

  function automatic logic [31:0] sh_word(logic [31:0] a);
    logic [31:0] base = {a[31:2], 2'b00};
    return {sh[ix(base + 3)], sh[ix(base + 2)], sh[ix(base + 1)], sh[ix(base)]};
  endfunction

  initial begin
    logic [31:0] rd, sa, exp, a, tgt, abase, wbase;
    logic [1:0]  ssz;
    logic [7:0]  pat [4];
    int          waits, wc0;
    pat[0] = 8'h01; pat[1] = 8'hFF; pat[2] = 8'h00; pat[3] = 8'h0E;

    repeat (3) @(posedge clk);
    #1;
    chk(s_req == 1'b0, "R6 reset idle", {31'b0, s_req}, 32'd0);
    rst_n = 1'b1;

    // R10: fill both bit-band windows with direct word writes, then read back
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 32; k++) begin
        wbase = r ? 32'h4000_0000 : 32'h2000_0000;
        a = wbase + 32'(4 * k);
        exp = 32'hA5C3_0000 ^ (32'(k) * 32'h0101_0107) ^ (r ? 32'h5A5A_5A5A : 32'h0);
        for (int b = 0; b < 4; b++) sh[ix(a + 32'(b))] = exp[8*b +: 8];
        ws = k % 2;
        xfer(a, 1'b1, 2'd2, exp, 1'b0, rd, waits, sa, ssz);
        if (k % 4 == 0) chk(sa == a, "R10 direct write address", sa, a);
      end
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < 32; k += 5) begin
        a = (r ? 32'h4000_0000 : 32'h2000_0000) + 32'(4 * k);
        xfer(a, 1'b0, 2'd2, 32'h0, 1'b0, rd, waits, sa, ssz);
        chk(rd == sh_word(a), "R10 direct read", rd, sh_word(a));
      end

    // R1: pass-through outside alias windows, byte write then word read
    ws = 1;
    a = 32'h6000_0011;
    xfer(a, 1'b1, 2'd0, 32'h0000_7E00, 1'b0, rd, waits, sa, ssz);
    sh[ix(a)] = 8'h7E;
    chk(sa == a, "R1 forward address", sa, a);
    chk(waits == 1, "R1 wait count", 32'(waits), 32'd1);
    xfer({a[31:2], 2'b00}, 1'b0, 2'd2, 32'h0, 1'b0, rd, waits, sa, ssz);
    chk(rd == sh_word(a), "R1 forward read data", rd, sh_word(a));

    // R2/R3/R4/R5/R6: exhaustive alias writes over 16 bytes x 8 bits in both windows
    for (int r = 0; r < 2; r++)
      for (int by = 0; by < 16; by++)
        for (int bt = 0; bt < 8; bt++) begin
          abase = r ? 32'h4200_0000 : 32'h2200_0000;
          wbase = r ? 32'h4000_0000 : 32'h2000_0000;
          a   = abase + 32'(by * 32 + bt * 4);
          tgt = wbase + 32'(by);
          ws  = (by + bt) % 2;
          wc0 = mem_wr_cnt;
          xfer(a, 1'b1, 2'd2, {24'hFFFF_FF, pat[(by + bt) % 4]}, 1'b0, rd, waits, sa, ssz);
          sh[ix(tgt)][bt] = pat[(by + bt) % 4][0];
          chk(waits == 2 * ws + 1, "R6 held not ready", 32'(waits), 32'(2 * ws + 1));
          chk(mem_wr_cnt == wc0 + 1, "R6 single memory write", 32'(mem_wr_cnt - wc0), 32'd1);
          chk(sa == {tgt[31:2], 2'b00}, r ? "R3 target address" : "R2 target address",
              sa, {tgt[31:2], 2'b00});
          xfer(a, 1'b0, 2'd2, 32'h0, 1'b0, rd, waits, sa, ssz);
          exp = {31'b0, sh[ix(tgt)][bt]};
          chk(rd == exp, "R4/R5 alias bit value", rd, exp);
          if (bt == 7) begin
            xfer(tgt, 1'b0, 2'd2, 32'h0, 1'b0, rd, waits, sa, ssz);
            chk(rd == sh_word(tgt), "R7 neighbours kept", rd, sh_word(tgt));
          end
        end

    // R9: halfword and byte alias writes keep size and align the address
    ws = 0;
    a = 32'h2200_0000 + 32'(5 * 32 + 3 * 4);
    xfer(a, 1'b1, 2'd1, 32'h0000_0001, 1'b0, rd, waits, sa, ssz);
    sh[ix(32'h2000_0005)][3] = 1'b1;
    chk(sa == 32'h2000_0004, "R9 halfword aligned address", sa, 32'h2000_0004);
    chk(ssz == 2'd1, "R9 halfword size", {30'b0, ssz}, 32'd1);
    xfer(32'h2000_0004, 1'b0, 2'd2, 32'h0, 1'b0, rd, waits, sa, ssz);
    chk(rd == sh_word(32'h2000_0004), "R7/R9 halfword merge", rd, sh_word(32'h2000_0004));
    a = 32'h4200_0000 + 32'(14 * 32 + 6 * 4);
    xfer(a, 1'b1, 2'd0, 32'h0000_00FE, 1'b0, rd, waits, sa, ssz);
    sh[ix(32'h4000_000E)][6] = 1'b0;
    chk(sa == 32'h4000_000E, "R9 byte address", sa, 32'h4000_000E);
    chk(ssz == 2'd0, "R9 byte size", {30'b0, ssz}, 32'd0);
    xfer(a, 1'b0, 2'd0, 32'h0, 1'b0, rd, waits, sa, ssz);
    chk(rd == 32'd0, "R4/R5 byte alias read", rd, 32'd0);

    // R8: fetch from alias space is not translated
    a = 32'h2200_0040;
    xfer(a, 1'b0, 2'd2, 32'h0, 1'b1, rd, waits, sa, ssz);
    chk(sa == a, "R8 fetch address", sa, a);
    chk(rd == sh_word(a), "R8 fetch data", rd, sh_word(a));

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    vecs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule